// File: doc/BRIEF.md
# Phase Detector and Charge-Pump Control

This block is the digital core of a frequency synthesizer loop. It compares single-cycle reference strobes with single-cycle strobes from the divided oscillator. It produces source (up) and sink (down) enables for an external charge pump, together with a current-select flag. It also decides the tuner band mode and drives three band-port enables.

Several settings can override the pump enables. A three-bit test selector can turn the pump off, hold it at sink only, or hold it at source only. The same selector can also put internal observation signals onto the band ports. An amplifier-off input parks the pump in sink. A standby band code holds the detector in reset.

A lock flag is set after a run of consecutive comparisons in which every correction pulse was narrow.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: `hi_cur_o` equals `cp_hi_i`: 1 selects the high pump current and 0 selects the low pump current.
- R2: `band_sel_i[1:0]` decodes as follows:
  - 00: no port driven, `band_mode_o` = 00 (UHF).
  - 01: `port_lo_o` = 1, mode 01 (VHF).
  - 10: `port_hi_o` = 1, mode 01 (VHF).
  - 11: neither port driven, mode 10 (standby).
  - `port_aux_o` follows `band_sel_i[2]` in every band mode, unless R4 applies.
- R3: `test_sel_i` = {t2,t1,t0} overrides the pump when the block is neither in standby nor amplifier-off:
  - 010: pump off (up 0, down 0).
  - 110: sink only (up 0, down 1).
  - 011: source only (up 1, down 0).
  - Every other code passes the detector outputs through.
- R4: `test_sel_i` = 100 puts `ref_pulse_i` on `port_aux_o`. `test_sel_i` = 101 puts a divide-by-2 of the divider strobes on `port_lo_o`. That flop starts at 0 and toggles on every `div_pulse_i`, in every mode.
- R5: `amp_off_i` = 1, outside standby, forces up 0 and down 1, whatever the test code. The detector state is kept and reappears when `amp_off_i` returns to 0.
- R6: Standby forces up 0 and down 0. It clears any pending detector state and clears the lock flag with its run count.
- R7: The detector works as follows:
  - A reference strobe sets up.
  - A divider strobe sets down.
  - On the edge where both would be set, both clear.
  - Up and down are never both 1 at the ports.
- R8: `lock_o` rises after 16 consecutive comparisons, each with a correction pulse of at most `MAX_W` clock cycles (default 4). Simultaneous strobes count as a width-0 comparison.
- R9: A correction pulse wider than `MAX_W` cycles clears `lock_o` and restarts the run count.
- R10: After reset, the detector is idle, `lock_o` = 0 and the divide-by-2 flop is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Reference comparison strobe |
| div_pulse_i | input | 1 | Divided-oscillator strobe |
| cp_hi_i | input | 1 | Pump current select |
| test_sel_i | input | 3 | Test code {t2,t1,t0} |
| amp_off_i | input | 1 | Tuning amplifier off, sink park |
| band_sel_i | input | 3 | {aux, high band, low band} |
| up_o | output | 1 | Pump source enable |
| dn_o | output | 1 | Pump sink enable |
| hi_cur_o | output | 1 | High current flag |
| port_lo_o | output | 1 | Low-band port enable |
| port_hi_o | output | 1 | High-band port enable |
| port_aux_o | output | 1 | Auxiliary port enable |
| band_mode_o | output | 2 | 00 UHF, 01 VHF, 10 standby |
| lock_o | output | 1 | Loop locked |

## Verification
All 256 combinations of band code, test code, amplifier-off and current select are swept with the detector idle. This sweep separates the priority of standby over amplifier-off over the test overrides, and checks the band decode against each test code.

Strobe pairs are then applied with the reference leading, the divider leading, and both together, at widths 0 to 4. These show which side the detector drives and how long it drives it.

Lock runs place the boundary width 4 and an over-wide width 5 at different points in the run. This separates a count of consecutive comparisons from a count of total comparisons. The observation codes are checked with live strobes while the detector is held in standby.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    MODE_UHF  = 2'b00,
    MODE_VHF  = 2'b01,
    MODE_STBY = 2'b10
  } band_mode_e;

  localparam logic [2:0] TM_OFF     = 3'b010;
  localparam logic [2:0] TM_SINK    = 3'b110;
  localparam logic [2:0] TM_SRC     = 3'b011;
  localparam logic [2:0] TM_REF_OBS = 3'b100;
  localparam logic [2:0] TM_DIV_OBS = 3'b101;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ref_i,
  input  logic div_i,
  output logic up_o,
  output logic dn_o,
  output logic cmp_o
);
  logic up_q, dn_q, up_set, dn_set;

  always_comb begin
    up_set = up_q | ref_i;
    dn_set = dn_q | div_i;
    cmp_o  = up_set & dn_set & ~hold_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (hold_i || (up_set && dn_set)) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set;
      dn_q <= dn_set;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/lock_det.sv
module lock_det #(
  parameter int MAX_W    = 4,
  parameter int LOCK_CNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic active_i,
  input  logic cmp_i,
  output logic lock_o
);
  localparam int WW = $clog2(MAX_W + 1);
  localparam int CW = $clog2(LOCK_CNT + 1);

  logic [WW-1:0] w_q;
  logic [CW-1:0] good_q;
  logic          lock_q;
  logic          viol;

  // pulse already longer than MAX_W cycles
  assign viol = active_i && (w_q == WW'(MAX_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   w_q <= '0;
    else if (hold_i || !active_i)  w_q <= '0;
    else if (w_q != WW'(MAX_W))    w_q <= w_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (hold_i || viol) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (cmp_i) begin
      if (good_q != CW'(LOCK_CNT)) good_q <= good_q + 1'b1;
      if (good_q >= CW'(LOCK_CNT - 1)) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pump_port_map.sv
module pump_port_map
  import pfd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] test_sel_i,
  input  logic       amp_off_i,
  input  logic [2:0] band_sel_i,
  input  logic       ref_i,
  input  logic       div_i,
  input  logic       pfd_up_i,
  input  logic       pfd_dn_i,
  output logic       stby_o,
  output logic       up_o,
  output logic       dn_o,
  output logic       port_lo_o,
  output logic       port_hi_o,
  output logic       port_aux_o,
  output logic [1:0] band_mode_o
);
  logic       div2_q;
  band_mode_e mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div2_q <= 1'b0;
    else if (div_i) div2_q <= ~div2_q;
  end

  always_comb begin
    stby_o = (band_sel_i[1:0] == 2'b11);
    unique case (band_sel_i[1:0])
      2'b00:   mode = MODE_UHF;
      2'b11:   mode = MODE_STBY;
      default: mode = MODE_VHF;
    endcase
  end

  // priority: standby, amp off, test override, detector
  always_comb begin
    up_o = pfd_up_i;
    dn_o = pfd_dn_i;
    if (stby_o) begin
      up_o = 1'b0;
      dn_o = 1'b0;
    end else if (amp_off_i) begin
      up_o = 1'b0;
      dn_o = 1'b1;
    end else begin
      case (test_sel_i)
        TM_OFF:  begin up_o = 1'b0; dn_o = 1'b0; end
        TM_SINK: begin up_o = 1'b0; dn_o = 1'b1; end
        TM_SRC:  begin up_o = 1'b1; dn_o = 1'b0; end
        default: ;
      endcase
    end
  end

  always_comb begin
    port_lo_o   = (test_sel_i == TM_DIV_OBS) ? div2_q : (band_sel_i[1:0] == 2'b01);
    port_hi_o   = (band_sel_i[1:0] == 2'b10);
    port_aux_o  = (test_sel_i == TM_REF_OBS) ? ref_i : band_sel_i[2];
    band_mode_o = mode;
  end
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl #(
  parameter int MAX_W    = 4,
  parameter int LOCK_CNT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_pulse_i,
  input  logic       div_pulse_i,
  input  logic       cp_hi_i,
  input  logic [2:0] test_sel_i,
  input  logic       amp_off_i,
  input  logic [2:0] band_sel_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       hi_cur_o,
  output logic       port_lo_o,
  output logic       port_hi_o,
  output logic       port_aux_o,
  output logic [1:0] band_mode_o,
  output logic       lock_o
);
  logic stby, pfd_up, pfd_dn, cmp;

  pump_port_map u_map (
    .clk_i, .rst_ni, .test_sel_i, .amp_off_i, .band_sel_i,
    .ref_i(ref_pulse_i), .div_i(div_pulse_i),
    .pfd_up_i(pfd_up), .pfd_dn_i(pfd_dn),
    .stby_o(stby), .up_o, .dn_o, .port_lo_o, .port_hi_o, .port_aux_o,
    .band_mode_o
  );

  pfd_core u_core (
    .clk_i, .rst_ni, .hold_i(stby),
    .ref_i(ref_pulse_i), .div_i(div_pulse_i),
    .up_o(pfd_up), .dn_o(pfd_dn), .cmp_o(cmp)
  );

  lock_det #(.MAX_W(MAX_W), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i, .rst_ni, .hold_i(stby),
    .active_i(pfd_up | pfd_dn), .cmp_i(cmp), .lock_o
  );

  assign hi_cur_o = cp_hi_i;
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
module pfd_pump_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] test_sel_i,
  input logic       amp_off_i,
  input logic [2:0] band_sel_i,
  input logic       up_o,
  input logic       dn_o,
  input logic       port_hi_o,
  input logic       port_aux_o,
  input logic [1:0] band_mode_o,
  input logic       lock_o
);
  // R7
  no_dual_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  // R6
  stby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_sel_i[1:0] == 2'b11) |-> (!up_o && !dn_o && band_mode_o == 2'b10));

  // R6
  stby_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_sel_i[1:0] == 2'b11) |=> !lock_o);

  // R5
  amp_off_sink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_off_i && band_sel_i[1:0] != 2'b11) |-> (dn_o && !up_o));

  // R2
  hi_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_sel_i[1:0] == 2'b10) |-> (port_hi_o && band_mode_o == 2'b01));

  // R2
  aux_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_sel_i != 3'b100) |-> (port_aux_o == band_sel_i[2]));
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk u_chk (.*);

// File: tb/pfd_pump_ctrl_bench.sv
module pfd_pump_ctrl_bench;
  localparam int MAX_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_p = 1'b0, div_p = 1'b0, cp = 1'b0, os = 1'b0;
  logic [2:0] tsel = 3'b000, band = 3'b000;
  logic up, dn, hic, plo, phi, paux, lck;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;
  bit div2 = 1'b0;

  always #5 clk = ~clk;

  pfd_pump_ctrl #(.MAX_W(MAX_W)) u_pfd_pump_ctrl (
    .clk_i(clk), .rst_ni, .ref_pulse_i(ref_p), .div_pulse_i(div_p),
    .cp_hi_i(cp), .test_sel_i(tsel), .amp_off_i(os), .band_sel_i(band),
    .up_o(up), .dn_o(dn), .hi_cur_o(hic), .port_lo_o(plo), .port_hi_o(phi),
    .port_aux_o(paux), .band_mode_o(mode), .lock_o(lck)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one comparison: lead strobe, k cycles later the lagging strobe (k=0: together)
  task automatic compare(input int k, input bit ref_lead);
    @(negedge clk);
    if (k == 0) begin ref_p = 1'b1; div_p = 1'b1; div2 = ~div2; end
    else if (ref_lead) ref_p = 1'b1;
    else begin div_p = 1'b1; div2 = ~div2; end
    for (int i = 1; i <= k; i++) begin
      @(negedge clk);
      ref_p = 1'b0; div_p = 1'b0;
      chk("R7 lead side", {up, dn}, ref_lead ? 2 : 1);
      if (i == k) begin
        if (ref_lead) begin div_p = 1'b1; div2 = ~div2; end
        else ref_p = 1'b1;
      end
    end
    @(negedge clk);
    ref_p = 1'b0; div_p = 1'b0;
    chk("R7 cleared", {up, dn}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk("R10 up/dn", {up, dn}, 0);
    chk("R10 lock", lck, 0);
    chk("R10 mode", mode, 0);
    chk("R10 ports", {plo, phi, paux}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // exhaustive static sweep, detector idle
    for (int b = 0; b < 8; b++)
      for (int t = 0; t < 8; t++)
        for (int o = 0; o < 2; o++)
          for (int c = 0; c < 2; c++) begin
            bit stby;
            int eu, ed, em;
            band = 3'(b); tsel = 3'(t); os = o[0]; cp = c[0];
            @(negedge clk);
            stby = (b[1:0] == 2'b11);
            em = stby ? 2 : (b[1:0] == 2'b00 ? 0 : 1);
            eu = 0; ed = 0;
            if (stby) begin eu = 0; ed = 0; end
            else if (o != 0) begin eu = 0; ed = 1; end
            else if (t == 6) ed = 1;
            else if (t == 3) eu = 1;
            chk(stby ? "R6 pump" : (o != 0 ? "R5 pump" : "R3 pump"), {up, dn}, eu * 2 + ed);
            chk("R1 current", hic, c);
            chk("R2 mode", mode, em);
            chk("R2 hi port", phi, b[1:0] == 2'b10);
            chk(t == 5 ? "R4 lo obs" : "R2 lo port", plo, (t == 5) ? 0 : (b[1:0] == 2'b01));
            chk(t == 4 ? "R4 aux obs" : "R2 aux port", paux, (t == 4) ? 0 : b[2]);
          end

    // R4 observation with strobes, detector held in standby
    band = 3'b011; tsel = 3'b100; os = 1'b0; cp = 1'b0;
    @(negedge clk);
    ref_p = 1'b1; #1;
    chk("R4 ref on aux", paux, 1);
    @(negedge clk);
    ref_p = 1'b0; #1;
    chk("R4 ref on aux low", paux, 0);
    tsel = 3'b101;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); div_p = 1'b1; div2 = ~div2;
      @(negedge clk); div_p = 1'b0;
      chk("R4 div2 on lo", plo, div2);
      chk("R6 held pump", {up, dn}, 0);
    end

    // detector in normal mode
    band = 3'b000; tsel = 3'b000;
    compare(3, 1'b1);
    compare(2, 1'b0);
    compare(0, 1'b1);
    chk("R8 no lock yet", lck, 0);

    // R8: 16 consecutive good compares, widths 0..4
    band = 3'b011; @(negedge clk); band = 3'b000;
    for (int i = 0; i < 16; i++) begin
      compare(i % 5, i[0]);
      chk("R8 lock run", lck, i == 15);
    end

    // R9: over-wide pulse clears lock, run restarts
    compare(MAX_W + 1, 1'b1);
    chk("R9 wide clears", lck, 0);
    for (int i = 0; i < 15; i++) compare(MAX_W, 1'b0);
    chk("R9 restart not yet", lck, 0);
    compare(MAX_W, 1'b1);
    chk("R9 relock", lck, 1);
    for (int i = 0; i < 10; i++) compare(1, 1'b1);
    compare(MAX_W + 1, 1'b0);
    chk("R9 wide after long run", lck, 0);

    // R5: amp off parks sink, detector state kept
    @(negedge clk); ref_p = 1'b1;
    @(negedge clk); ref_p = 1'b0;
    chk("R7 pending up", {up, dn}, 2);
    os = 1'b1;
    @(negedge clk);
    chk("R5 sink park", {up, dn}, 1);
    os = 1'b0;
    @(negedge clk);
    chk("R5 state kept", {up, dn}, 2);

    // R6: standby clears pending state and lock
    band = 3'b011;
    @(negedge clk);
    chk("R6 standby off", {up, dn}, 0);
    band = 3'b000;
    @(negedge clk);
    chk("R6 pending cleared", {up, dn}, 0);
    for (int i = 0; i < 16; i++) compare(1, 1'b1);
    chk("R8 lock again", lck, 1);
    band = 3'b001;
    @(negedge clk);
    chk("R2 VHF keeps lock", lck, 1);
    band = 3'b011;
    @(negedge clk);
    chk("R6 standby unlock", lck, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule